// File: doc/BRIEF.md
# Raster frequency mark generator

This block places frequency-scale tick marks on a raster display. Each line sync pulse stands for one display line. The block counts these pulses and lights a mark on every twentieth line, so the ticks are spaced evenly across the frequency axis of the picture. A mark is not visible along its whole line. It shows only inside two short timed windows. The first window opens when the raster line starts and draws the lower row of ticks. The second window opens a fixed time later and draws the upper row.

The inputs are a single-cycle line sync pulse, a single-cycle raster-line start pulse and a format select. The main output is one video bit that a later mixer ORs or XORs into the picture. A separate small output reports how many MHz one tick spacing stands for in the selected format. The format select changes only this reported step. It never changes the spacing of the marks. All window timing comes from a microsecond tick, which a prescaler derives from the system clock and restarts at every line start.

Top module: `freq_mark_gen`

## Requirements
- R1: After reset, the mark flag sets on the MARK_DIV-th line sync pulse and again on every MARK_DIV-th pulse after that. The flag is seen in the cycle after the pulse is sampled.
- R2: The flag clears on the next line sync pulse after the one that set it, so each mark covers exactly one line. This holds even when sync pulses arrive on consecutive cycles.
- R3: Cycles without a line sync pulse leave the sync count and the mark flag unchanged, whatever the spacing between pulses.
- R4: The lower window is open for BOT_LEN_US × CLK_PER_US cycles, starting in the cycle after a line start pulse is sampled.
- R5: The upper window opens TOP_DELAY_US × CLK_PER_US cycles after the lower window opens. It stays open for TOP_LEN_US × CLK_PER_US cycles and then stays closed until the next line start.
- R6: `mark_video_o` is 1 only when the mark flag is set and one of the two windows is open. It is 0 at every other time.
- R7: A synchronous reset clears the sync count and the mark flag and closes both windows. They stay closed until the next line start pulse.
- R8: `scale_step_o` is 1 when `fmt_wide_i` is 0 (narrow format, 1 MHz per mark). It is 2 when `fmt_wide_i` is 1 (wide format, 2 MHz per mark).
- R9: Changing `fmt_wide_i` at any time leaves the mark spacing and the window timing unchanged.
- R10: A line start pulse that arrives while the windows are still timing restarts the timing from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| line_sync_i | input | 1 | One-cycle pulse for each display line |
| line_start_i | input | 1 | One-cycle pulse at the start of each raster line |
| fmt_wide_i | input | 1 | 0 = narrow format, 1 = wide format |
| mark_video_o | output | 1 | Mark video bit, 1 = white |
| scale_step_o | output | 2 | MHz represented by one mark spacing |

## Verification
The bench builds the block with CLK_PER_US = 3 and MARK_DIV = 5. The window lengths and the upper-window delay keep their default values. With these settings a whole line, including the late upper window, fits in 200 cycles, and a mark comes round every fifth line. This makes it practical to cover many wrap-arounds of the sync counter, the edges of both windows, back-to-back sync bursts, restarts in mid-line and a reset in mid-run. It also allows a long stretch of irregular traffic.

// File: rtl/fmg_pkg.sv
package fmg_pkg;
    typedef enum logic {
        FMT_NARROW = 1'b0,
        FMT_WIDE   = 1'b1
    } fmt_e;

    localparam logic [1:0] STEP_NARROW = 2'd1;
    localparam logic [1:0] STEP_WIDE   = 2'd2;
endpackage

// File: rtl/fmg_line_div.sv
module fmg_line_div #(
    parameter int MARK_DIV = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic line_sync_i,
    output logic mark_o
);
    localparam int CW = (MARK_DIV > 2) ? $clog2(MARK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(MARK_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mark;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (line_sync_i) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt  = '0;
                st_d.mark = 1'b1;
            end else begin
                st_d.cnt  = st_q.cnt + 1'b1;
                st_d.mark = 1'b0;
            end
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mark_o = st_q.mark;

    // R2: a set flag lasts only until the next sync pulse
    a_r2_one_line_mark: assert property (@(posedge clk) disable iff (rst)
        (line_sync_i && st_q.mark) |=> !mark_o);

    // R3: no pulse, no change
    a_r3_hold_between_syncs: assert property (@(posedge clk) disable iff (rst)
        !line_sync_i |=> $stable(st_q));

    // R1: the flag rises only at the wrap of the count
    a_r1_rise_on_wrap: assert property (@(posedge clk) disable iff (rst)
        $rose(mark_o) |-> (st_q.cnt == '0));

    // R7: reset leaves the flag and the count cleared
    a_r7_reset_clears: assert property (@(posedge clk)
        rst |=> (st_q.cnt == '0) && !mark_o);
endmodule

// File: rtl/fmg_timebase.sv
module fmg_timebase #(
    parameter int CLK_PER_US = 50,
    parameter int US_MAX     = 65
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          line_start_i,
    output logic                          run_o,
    output logic [$clog2(US_MAX+1)-1:0]   us_o
);
    localparam int UW = $clog2(US_MAX + 1);
    localparam int PW = (CLK_PER_US > 2) ? $clog2(CLK_PER_US) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(CLK_PER_US - 1);
    localparam logic [UW-1:0] US_TOP   = UW'(US_MAX);

    typedef struct packed {
        logic          run;
        logic [PW-1:0] pre;
        logic [UW-1:0] us;
    } tb_st_t;

    tb_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (line_start_i) begin
            st_d.run = 1'b1;
            st_d.pre = '0;
            st_d.us  = '0;
        end else if (st_q.run) begin
            if (st_q.pre == PRE_LAST) begin
                st_d.pre = '0;
                if (st_q.us != US_TOP) begin
                    st_d.us = st_q.us + 1'b1;
                end
            end else begin
                st_d.pre = st_q.pre + 1'b1;
            end
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign run_o = st_q.run;
    assign us_o  = st_q.us;

    // R10: a line start restarts the timebase from zero
    a_r10_restart: assert property (@(posedge clk) disable iff (rst)
        line_start_i |=> run_o && (us_o == '0));

    // R5: the microsecond count never steps backwards within a line
    a_r5_us_monotone: assert property (@(posedge clk) disable iff (rst)
        (run_o && !line_start_i) |=> (us_o >= $past(us_o)));
endmodule

// File: rtl/fmg_window.sv
module fmg_window #(
    parameter int UW      = 7,
    parameter int OPEN_US = 0,
    parameter int LEN_US  = 2
) (
    input  logic          run_i,
    input  logic [UW-1:0] us_i,
    output logic          open_o
);
    localparam logic [UW-1:0] FROM_US = UW'(OPEN_US);
    localparam logic [UW-1:0] UPTO_US = UW'(OPEN_US + LEN_US);

    always_comb begin
        open_o = run_i && (us_i >= FROM_US) && (us_i < UPTO_US);
    end
endmodule

// File: rtl/freq_mark_gen.sv
module freq_mark_gen #(
    parameter int CLK_PER_US   = 50,
    parameter int MARK_DIV     = 20,
    parameter int BOT_LEN_US   = 2,
    parameter int TOP_DELAY_US = 63,
    parameter int TOP_LEN_US   = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_sync_i,
    input  logic       line_start_i,
    input  logic       fmt_wide_i,
    output logic       mark_video_o,
    output logic [1:0] scale_step_o
);
    import fmg_pkg::*;

    localparam int TOP_END = TOP_DELAY_US + TOP_LEN_US;
    localparam int US_MAX  = (TOP_END > BOT_LEN_US) ? TOP_END : BOT_LEN_US;
    localparam int UW      = $clog2(US_MAX + 1);
    localparam int NWIN    = 2;
    localparam int WIN_AT  [NWIN] = '{0, TOP_DELAY_US};
    localparam int WIN_LEN [NWIN] = '{BOT_LEN_US, TOP_LEN_US};

    logic          mark_q;
    logic          run;
    logic [UW-1:0] us;
    logic [NWIN-1:0] win_open;
    fmt_e          fmt;

    fmg_line_div #(.MARK_DIV(MARK_DIV)) u_div (
        .clk         (clk),
        .rst         (rst),
        .line_sync_i (line_sync_i),
        .mark_o      (mark_q)
    );

    fmg_timebase #(.CLK_PER_US(CLK_PER_US), .US_MAX(US_MAX)) u_time (
        .clk          (clk),
        .rst          (rst),
        .line_start_i (line_start_i),
        .run_o        (run),
        .us_o         (us)
    );

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        fmg_window #(.UW(UW), .OPEN_US(WIN_AT[w]), .LEN_US(WIN_LEN[w])) u_win (
            .run_i  (run),
            .us_i   (us),
            .open_o (win_open[w])
        );
    end

    assign fmt          = fmt_e'(fmt_wide_i);
    assign mark_video_o = mark_q && (|win_open);
    assign scale_step_o = (fmt == FMT_WIDE) ? STEP_WIDE : STEP_NARROW;

    // R6: video only when a window is open and a mark is held
    a_r6_video_needs_window: assert property (@(posedge clk) disable iff (rst)
        mark_video_o |-> run && (|win_open));

    // R8: the reported step is one of the two legal codes
    a_r8_step_legal: assert property (@(posedge clk) disable iff (rst)
        (scale_step_o == 2'd1) || (scale_step_o == 2'd2));
endmodule

// File: tb/tb_freq_mark_gen.sv
module tb_freq_mark_gen;
    localparam int CLK_PERIOD = 10;
    localparam int P   = 3;
    localparam int DIV = 5;
    localparam int BOT = 2;
    localparam int TD  = 63;
    localparam int TL  = 2;
    localparam int LINE = 200;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_sync_i = 1'b0;
    logic       line_start_i = 1'b0;
    logic       fmt_wide_i = 1'b0;
    logic       mark_video_o;
    logic [1:0] scale_step_o;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    bit started = 1'b0;
    string phase = "R7";

    int m_cnt = 0;
    int m_mark = 0;
    int m_n = -1;
    bit m_rst = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    freq_mark_gen #(
        .CLK_PER_US(P), .MARK_DIV(DIV), .BOT_LEN_US(BOT),
        .TOP_DELAY_US(TD), .TOP_LEN_US(TL)
    ) dut (
        .clk(clk), .rst(rst), .line_sync_i(line_sync_i),
        .line_start_i(line_start_i), .fmt_wide_i(fmt_wide_i),
        .mark_video_o(mark_video_o), .scale_step_o(scale_step_o)
    );

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        started <= 1'b1;
        cyc <= cyc + 1;
        m_rst = rst;
        if (rst) begin
            m_cnt = 0; m_mark = 0; m_n = -1;
        end else begin
            if (line_sync_i) begin
                m_cnt = m_cnt + 1;
                if (m_cnt == DIV) begin m_cnt = 0; m_mark = 1; end
                else m_mark = 0;
            end
            if (line_start_i) m_n = 0;
            else if (m_n >= 0 && m_n < 100000) m_n = m_n + 1;
        end
    end

    function automatic bit in_bot(int n);
        return n >= 0 && n < BOT*P;
    endfunction
    function automatic bit in_top(int n);
        return n >= TD*P && n < (TD+TL)*P;
    endfunction

    always @(negedge clk) begin
        if (started) begin
            automatic bit exp_v = (m_mark != 0) && (in_bot(m_n) || in_top(m_n));
            automatic logic [1:0] exp_s = fmt_wide_i ? 2'd2 : 2'd1;
            automatic string tag;
            if (m_rst) tag = "R7";
            else if (m_mark != 0 && in_bot(m_n)) tag = "R4";
            else if (m_mark != 0 && in_top(m_n)) tag = "R5";
            else tag = phase;
            n_vec++;
            if (mark_video_o !== exp_v) begin
                n_bad++;
                $display("FAIL %s cycle %0d mark_video_o got %b expected %b", tag, cyc, mark_video_o, exp_v);
            end
            n_vec++;
            if (scale_step_o !== exp_s) begin
                n_bad++;
                $display("FAIL R8 cycle %0d scale_step_o got %0d expected %0d", cyc, scale_step_o, exp_s);
            end
        end
    end

    task automatic finish_up();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog cycle %0d expected run to end", cyc);
            finish_up();
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // one raster line: start at index 0, sync at index sync_at (negative = none)
    task automatic run_line(int len, int sync_at);
        for (int i = 0; i < len; i++) begin
            step();
            line_start_i = (i == 0);
            line_sync_i  = (i == sync_at);
        end
        step();
        line_start_i = 1'b0;
        line_sync_i  = 1'b0;
    endtask

    initial begin
        phase = "R7";
        for (int i = 0; i < 5; i++) step();
        rst = 1'b0;

        phase = "R1";
        for (int l = 0; l < 3*DIV + 2; l++) run_line(LINE, 0);

        phase = "R9";
        for (int l = 0; l < 2*DIV + 1; l++) begin
            fmt_wide_i = l[0];
            run_line(LINE, 7);
        end
        fmt_wide_i = 1'b1;

        phase = "R3";
        for (int l = 0; l < 2*DIV; l++) run_line(LINE, (l * 37) % LINE);

        phase = "R10";
        for (int l = 0; l < 2*DIV; l++) begin
            run_line(TD*P + 2, 0);
            run_line(5, -1);
            run_line(LINE, 1);
        end

        phase = "R2";
        for (int l = 0; l < 4; l++) begin
            step();
            line_start_i = 1'b1;
            for (int k = 0; k < 3*DIV; k++) begin
                line_sync_i = 1'b1;
                step();
                line_start_i = 1'b0;
            end
            line_sync_i = 1'b0;
            run_line(LINE, -1);
        end

        phase = "R7";
        run_line(LINE / 2, 0);
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
        for (int i = 0; i < 30; i++) step();
        for (int l = 0; l < DIV + 1; l++) run_line(LINE, 0);

        phase = "R6";
        for (int i = 0; i < 20000; i++) begin
            step();
            line_sync_i  = (($urandom % 40) == 0);
            line_start_i = (($urandom % 230) == 0);
            if (($urandom % 500) == 0) fmt_wide_i = ~fmt_wide_i;
        end
        line_sync_i = 1'b0;
        line_start_i = 1'b0;
        step(); step();
        finish_up();
    end
endmodule